// File: doc/BRIEF.md
# Power-Factor Stage Standby Supervisor

This block decides, once per clock, whether the power-factor-correction front stage of a switching supply may run. It receives already-compared digital flags: two feedback comparisons that mark the light-load skip band (feedback below the skip setpoint, and feedback above the exit level of about 1.7 times that setpoint), a maximum-power error flag, a confirmed-fault burst flag, a permanent shutdown flag and a slow timer-tick strobe. From these it drives one registered enable, `pfc_on`.

An internal hysteresis latch turns the two feedback comparisons into a single skip-activity signal. At power-up the enable stays low until the error flag clears for the first time. Entry into standby has to be confirmed: skip activity must last for a programmable number of timer ticks. Leaving standby takes effect on the very next clock edge. A fault burst holds the enable low until the fault is gone and regulation is back. A permanent shutdown holds it low until reset.

Top module: `pfc_gate_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the machine in the power-up state (state code 0) with `pfc_on` low.
- R2: In power-up, `pfc_on` stays low while `err_i` is high. The first clock edge that samples `err_i` low, with no burst or shutdown present, moves the machine to normal (code 1) and sets `pfc_on` high.
- R3: Skip activity begins when `fb_low_i` is sampled high. It persists while neither feedback flag is high, and it ends only when `fb_high_i` is sampled high. When both flags are high together, `fb_high_i` wins and there is no activity.
- R4: Skip activity seen in normal moves the machine to standby-pending (code 2), and `pfc_on` stays high.
- R5: In standby-pending, the edge that samples the CONFIRM_TICKS-th `tick_i` pulse, with skip activity still present, moves the machine to standby (code 3) and drops `pfc_on`. Ticks sampled outside standby-pending are not counted.
- R6: If skip activity ends while in standby-pending, the machine returns to normal with `pfc_on` high. This also holds when activity ends in the same cycle as the final tick. A later entry into standby-pending starts the count from zero.
- R7: In standby, the edge that samples the end of skip activity returns the machine to normal and sets `pfc_on` high at that same edge.
- R8: `burst_i` high moves the machine to fault (code 4) with `pfc_on` low. The machine leaves fault for normal only on an edge that samples both `burst_i` and `err_i` low.
- R9: `latch_i` high moves the machine to latched (code 5) from any state with `pfc_on` low. The machine stays there, whatever the other inputs do, until reset.
- R10: Priority on a single edge: shutdown over burst, and burst over skip or error handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_low_i | input | 1 | Feedback below the skip setpoint |
| fb_high_i | input | 1 | Feedback above the skip exit level |
| err_i | input | 1 | Maximum-power error flag |
| burst_i | input | 1 | Confirmed fault, burst mode active |
| latch_i | input | 1 | Permanent shutdown request |
| tick_i | input | 1 | Timer tick strobe, one cycle wide |
| pfc_on | output | 1 | Front-stage enable (registered) |
| state_o | output | 3 | Current state code |

## Verification
Two events can land in the same cycle: the final confirmation tick of standby-pending and the end of skip activity. The bench runs the machine into standby-pending and delivers one tick fewer than the limit. It then raises `fb_high_i` together with the last tick and expects normal with `pfc_on` high, not standby. A second race is a burst or shutdown that arrives alongside skip or burst inputs. The bench judges it by the state code and enable after that edge, following the priority in R10.

// File: rtl/pfc_gate_pkg.sv
package pfc_gate_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP   = 3'd0,
    ST_NORMAL  = 3'd1,
    ST_PENDING = 3'd2,
    ST_STANDBY = 3'd3,
    ST_FAULT   = 3'd4,
    ST_LATCHED = 3'd5
  } pfc_state_t;
endpackage

// File: rtl/pfc_skip_hyst.sv
module pfc_skip_hyst (
  input  logic clk,
  input  logic rst,
  input  logic fb_low_i,
  input  logic fb_high_i,
  output logic act_o
);
  logic held_q;

  always_comb begin
    if (fb_high_i)     act_o = 1'b0;
    else if (fb_low_i) act_o = 1'b1;
    else               act_o = held_q;
  end

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= act_o;
  end

  // R3: activity only ends through the exit comparison
  assert_skip_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (act_o && !fb_high_i) |=> (act_o || fb_high_i));
endmodule

// File: rtl/pfc_confirm_timer.sv
module pfc_confirm_timer #(
  parameter int unsigned CONFIRM_TICKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CONFIRM_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(CONFIRM_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i)
      cnt_q <= '0;
    else if (tick_i && cnt_q != LAST)
      cnt_q <= cnt_q + 1'b1;
  end

  // R5: count never runs past the confirmation limit
  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R6: count restarts from zero once pending is left
  assert_cnt_restart_R6: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/pfc_gate_ctrl.sv
module pfc_gate_ctrl #(
  parameter int unsigned CONFIRM_TICKS = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fb_low_i,
  input  logic       fb_high_i,
  input  logic       err_i,
  input  logic       burst_i,
  input  logic       latch_i,
  input  logic       tick_i,
  output logic       pfc_on,
  output logic [2:0] state_o
);
  import pfc_gate_pkg::*;

  pfc_state_t st_q, st_n;
  logic skip_act;
  logic confirm_done;

  pfc_skip_hyst u_hyst (
    .clk      (clk),
    .rst      (rst),
    .fb_low_i (fb_low_i),
    .fb_high_i(fb_high_i),
    .act_o    (skip_act)
  );

  pfc_confirm_timer #(.CONFIRM_TICKS(CONFIRM_TICKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (st_q == ST_PENDING),
    .tick_i (tick_i),
    .done_o (confirm_done)
  );

  always_comb begin
    st_n = st_q;
    if (st_q == ST_LATCHED || latch_i) begin
      st_n = ST_LATCHED;
    end else if (burst_i) begin
      st_n = ST_FAULT;
    end else begin
      unique case (st_q)
        ST_PWRUP:   if (!err_i) st_n = ST_NORMAL;
        ST_NORMAL:  if (skip_act) st_n = ST_PENDING;
        ST_PENDING: begin
          if (!skip_act)         st_n = ST_NORMAL;
          else if (confirm_done) st_n = ST_STANDBY;
        end
        ST_STANDBY: if (!skip_act) st_n = ST_NORMAL;
        ST_FAULT:   if (!err_i) st_n = ST_NORMAL;
        default:    st_n = ST_LATCHED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_PWRUP;
      pfc_on <= 1'b0;
    end else begin
      st_q   <= st_n;
      pfc_on <= (st_n == ST_NORMAL) || (st_n == ST_PENDING);
    end
  end

  assign state_o = st_q;

  // R2: no enable before the error flag has cleared once
  assert_pwrup_off_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PWRUP) |-> !pfc_on);
  // R8: a burst always leaves the enable low
  assert_burst_off_R8: assert property (@(posedge clk) disable iff (rst)
    burst_i |=> !pfc_on);
  // R9: shutdown is sticky
  assert_latch_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LATCHED) |=> (st_q == ST_LATCHED) && !pfc_on);
  // R7: leaving standby takes one edge
  assert_fast_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STANDBY && !skip_act && !burst_i && !latch_i) |=> pfc_on);
  // R5: standby is only reached from pending through a confirmed count
  assert_confirmed_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_STANDBY && st_q != ST_LATCHED && st_n == ST_STANDBY)
      |-> (st_q == ST_PENDING && confirm_done));
endmodule

// File: tb/pfc_gate_ctrl_test.sv
module pfc_gate_ctrl_test;
  localparam int unsigned N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_low = 1'b0, fb_high = 1'b0, err = 1'b1, burst = 1'b0, latch = 1'b0, tick = 1'b0;
  logic pfc_on;
  logic [2:0] state;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pfc_gate_ctrl #(.CONFIRM_TICKS(N)) uut (
    .clk(clk), .rst(rst), .fb_low_i(fb_low), .fb_high_i(fb_high),
    .err_i(err), .burst_i(burst), .latch_i(latch), .tick_i(tick),
    .pfc_on(pfc_on), .state_o(state)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] exp_st, input logic exp_on);
    checks++;
    if (state !== exp_st || pfc_on !== exp_on) begin
      errors++;
      $display("FAIL %s: state=%0d pfc_on=%b expected state=%0d pfc_on=%b",
               req, state, pfc_on, exp_st, exp_on);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(); tick = 1'b0; step();
    end
  endtask

  task automatic end_skip();
    fb_high = 1'b1; step(); fb_high = 1'b0;
  endtask

  task automatic t_reset_powerup();
    rst = 1'b1; err = 1'b1; step(); step();
    rst = 1'b0;
    chk("R1 reset", 3'd0, 1'b0);
    for (int i = 0; i < 4; i++) step();
    chk("R2 held while error", 3'd0, 1'b0);
    err = 1'b0; step();
    chk("R2 first error clear", 3'd1, 1'b1);
  endtask

  task automatic t_confirm();
    fb_low = 1'b1; fb_high = 1'b1; step();
    chk("R3 both flags, exit wins", 3'd1, 1'b1);
    fb_high = 1'b0; tick = 1'b1; step();
    fb_low = 1'b0; tick = 1'b0;
    chk("R4 enter pending", 3'd2, 1'b1);
    step(); step();
    chk("R3 activity held between flags", 3'd2, 1'b1);
    ticks(N - 1);
    chk("R5 one tick short, tick in normal not counted", 3'd2, 1'b1);
    ticks(1);
    chk("R5 standby confirmed", 3'd3, 1'b0);
    step();
    chk("R5 standby holds", 3'd3, 1'b0);
    end_skip();
    chk("R7 immediate exit", 3'd1, 1'b1);
  endtask

  task automatic t_abort();
    fb_low = 1'b1; step(); fb_low = 1'b0;
    chk("R4 pending again", 3'd2, 1'b1);
    ticks(N - 1);
    tick = 1'b1; fb_high = 1'b1; step(); tick = 1'b0; fb_high = 1'b0;
    chk("R6 exit on final tick wins", 3'd1, 1'b1);
    fb_low = 1'b1; step(); fb_low = 1'b0;
    ticks(N - 1);
    chk("R6 count restarted", 3'd2, 1'b1);
    end_skip();
    chk("R6 early exit", 3'd1, 1'b1);
  endtask

  task automatic t_fault();
    burst = 1'b1; fb_low = 1'b1; step(); fb_low = 1'b0;
    chk("R10 burst over skip", 3'd4, 1'b0);
    burst = 1'b0; err = 1'b1; step();
    chk("R8 held while error", 3'd4, 1'b0);
    fb_high = 1'b1; err = 1'b0; step(); fb_high = 1'b0;
    chk("R8 recovery", 3'd1, 1'b1);
  endtask

  task automatic t_latch();
    latch = 1'b1; burst = 1'b1; step();
    chk("R10 shutdown over burst", 3'd5, 1'b0);
    latch = 1'b0; burst = 1'b0; err = 1'b0;
    for (int i = 0; i < 3; i++) step();
    chk("R9 sticky", 3'd5, 1'b0);
    fb_high = 1'b1; step(); fb_high = 1'b0;
    chk("R9 ignores skip exit", 3'd5, 1'b0);
    rst = 1'b1; err = 1'b1; step(); rst = 1'b0;
    chk("R1 reset clears shutdown", 3'd0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset_powerup();
    t_confirm();
    t_abort();
    t_fault();
    t_latch();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule